// File: doc/BRIEF.md
# Sampling Converter Serial Port Sequencer

This block is the digital control side of a 10-bit sampling converter that talks to a host over a three-wire serial port. The host lowers an active-low chip-select to open a frame and toggles a serial clock; the block latches the parallel result from a converter core at the opening edge, and shifts it out as a 16-bit word. Each bit is launched on a falling serial-clock edge. The block also drives the track/hold switch of the core, an output enable for the serial data pin, and a power-mode status.

The chip-select and serial-clock pins are sampled in a fast system clock domain. Edges are found by comparing each pin with its value one system clock earlier. The serial-clock edges of a frame are counted, and the number of falling edges seen when chip-select rises selects the power-mode action. The choices are to keep the mode, to enter shutdown, or to keep running while cutting the word short. The first conversion after reset or after shutdown is flagged as a dummy. A parameter chooses whether the block leaves reset in normal mode or in shutdown.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset the outputs are as follows. `sdata_oe`, `sdata`, `hold` and `invalid` are 0. `pmode` is 0 (normal) when `RESET_SHUTDOWN` is 0, and 1 (shutdown) when it is 1. `pmode` uses 0 for normal, 1 for shutdown and 2 for powering up.
- R2: A falling edge on `cs_n` has three effects: `sdata_oe` goes to 1, `hold` goes to 1, and `core_data` is latched. The outputs change one system clock after the edge is seen.
- R3: Let n be the number of falling `sclk` edges seen in the frame, for n from 0 to 15. While the output is enabled, `sdata` is bit (13-n) of the latched word when n is between 4 and 13, and 0 otherwise. This gives four zeros, the ten bits in straight binary with the most significant bit first, then two zeros. Changes to `core_data` after the latch have no effect, and `sdata` is 0 whenever the output is disabled.
- R4: `hold` returns to 0 on the 13th rising `sclk` edge of the frame.
- R5: `sdata_oe` returns to 0 on the 16th falling `sclk` edge. It stays 0 for any further clocks while `cs_n` is held low. The edge counters saturate at 16.
- R6: A rising edge on `cs_n` forces `sdata_oe` and `hold` to 0, which truncates the word.
- R7: In normal mode, a rising edge on `cs_n` after fewer than 2 falling `sclk` edges leaves the mode unchanged.
- R8: In normal mode, a rising edge on `cs_n` after 2 to 9 falling edges puts the block in shutdown.
- R9: In normal mode, a rising edge on `cs_n` after 10 or more falling edges keeps normal mode.
- R10: Each of these steps applies from shutdown.
  - A falling edge on `cs_n` moves the block to powering up (2).
  - The 10th falling `sclk` edge of that frame moves it to normal mode.
  - A rising edge on `cs_n` before that edge returns it to shutdown.
  - Shutdown never moves straight to normal.
- R11: `invalid` is 1 for a frame if that frame is the first since reset or the first since the block entered shutdown, and 0 for other frames. The value is set at the frame's `cs_n` falling edge and held until the next one.
- R12: `sclk` edges while `cs_n` is high have no effect. The output stays disabled, and the next frame counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip-select, synchronous to clk |
| sclk | input | 1 | Serial clock level, synchronous to clk |
| core_data | input | 10 | Parallel result from the converter core |
| sdata | output | 1 | Serial data value (0 when disabled) |
| sdata_oe | output | 1 | Enable for the tri-state serial data driver |
| hold | output | 1 | Track/hold control, 1 = hold |
| pmode | output | 2 | Power mode: 0 normal, 1 shutdown, 2 powering up |
| invalid | output | 1 | Current frame's result is a dummy |

## Verification
Some rules are checked by assertions on every cycle:
- A frame start always enables the output and holds the input.
- A chip-select rise always releases both.
- The output is never enabled once 16 falling edges are counted.
- `hold` is low once 13 rising edges are counted.
- Shutdown never moves straight to normal.
- A frame opened outside normal mode is flagged invalid.

Other behaviour can only be shown by the bench's scenarios, which compare the block against a cycle-by-cycle reference model. These cover:
- the exact serial bit order with a changing `core_data`;
- the three chip-select rise windows in each mode;
- the powering-up retry that falls back to shutdown;
- the dummy flag clearing on the frame after;
- the start-up case with shutdown as the reset mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DATA_W     = 10;
    localparam int FRAME_LEN  = 16;
    localparam int FIRST_DATA = 4;
    localparam int HOLD_RISE  = 13;
    localparam int SHDN_FROM  = 2;
    localparam int KEEP_FROM  = 10;
    localparam int CNT_W      = $clog2(FRAME_LEN + 1);

    typedef enum logic [1:0] {
        PM_NORMAL   = 2'd0,
        PM_SHUTDOWN = 2'd1,
        PM_WAKING   = 2'd2
    } pmode_e;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic clk_fall;
        logic clk_rise;
    } ev_t;

    function automatic logic frame_bit(input logic [CNT_W-1:0] n,
                                       input logic [DATA_W-1:0] w);
        logic b;
        b = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (int'(n) == FIRST_DATA + DATA_W - 1 - i) b = w[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/adc_seq_edges.sv
module adc_seq_edges
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    output ev_t  ev
);
    logic cs_q;
    logic sclk_q;
    logic in_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    assign in_frame    = ~cs_q & ~cs_n;
    assign ev.cs_fall  = cs_q & ~cs_n;
    assign ev.cs_rise  = ~cs_q & cs_n;
    assign ev.clk_fall = in_frame & sclk_q & ~sclk;
    assign ev.clk_rise = in_frame & ~sclk_q & sclk;

endmodule

// File: rtl/adc_seq_count.sv
module adc_seq_count #(
    parameter int W     = 5,
    parameter int LIMIT = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LIMIT_C = W'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clr)                  cnt <= '0;
        else if (inc && cnt != LIMIT_C)  cnt <= cnt + 1'b1;
    end

    a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT_C);

endmodule

// File: rtl/adc_seq_mode.sv
module adc_seq_mode
    import adc_seq_pkg::*;
#(
    parameter bit RESET_SHUTDOWN = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  ev_t              ev,
    input  logic [CNT_W-1:0] fall_cnt,
    output pmode_e           mode,
    output logic             invalid
);
    localparam logic [CNT_W-1:0] SHDN_C = CNT_W'(SHDN_FROM);
    localparam logic [CNT_W-1:0] KEEP_C = CNT_W'(KEEP_FROM);
    localparam logic [CNT_W-1:0] WAKE_C = CNT_W'(KEEP_FROM - 1);
    localparam pmode_e RESET_MODE = RESET_SHUTDOWN ? PM_SHUTDOWN : PM_NORMAL;

    logic need_q;
    logic go_down;

    assign go_down = ev.cs_rise &&
                     ((mode == PM_WAKING && fall_cnt < KEEP_C) ||
                      (mode == PM_NORMAL && fall_cnt >= SHDN_C && fall_cnt < KEEP_C));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= RESET_MODE;
            need_q  <= 1'b1;
            invalid <= 1'b0;
        end else if (ev.cs_fall) begin
            invalid <= need_q;
            need_q  <= 1'b0;
            if (mode == PM_SHUTDOWN) mode <= PM_WAKING;
        end else if (go_down) begin
            mode   <= PM_SHUTDOWN;
            need_q <= 1'b1;
        end else if (ev.clk_fall && mode == PM_WAKING && fall_cnt == WAKE_C) begin
            mode <= PM_NORMAL;
        end
    end

    a_r10_no_skip: assert property (@(posedge clk) disable iff (rst)
        mode == PM_SHUTDOWN |=> mode != PM_NORMAL);
    a_r10_wake: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SHUTDOWN && ev.cs_fall) |=> mode == PM_WAKING);
    a_r7_early_rise: assert property (@(posedge clk) disable iff (rst)
        (ev.cs_rise && mode == PM_NORMAL && fall_cnt < SHDN_C) |=> mode == PM_NORMAL);
    a_r11_dummy: assert property (@(posedge clk) disable iff (rst)
        (ev.cs_fall && mode != PM_NORMAL) |=> invalid);

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
    import adc_seq_pkg::*;
#(
    parameter bit RESET_SHUTDOWN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] core_data,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              hold,
    output logic [1:0]        pmode,
    output logic              invalid
);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_HOLD = CNT_W'(HOLD_RISE - 1);
    localparam logic [CNT_W-1:0] HOLD_C    = CNT_W'(HOLD_RISE);
    localparam logic [CNT_W-1:0] FRAME_C   = CNT_W'(FRAME_LEN);

    ev_t               ev;
    logic [CNT_W-1:0]  fall_cnt;
    logic [CNT_W-1:0]  rise_cnt;
    logic [DATA_W-1:0] word_q;
    pmode_e            mode;

    adc_seq_edges u_edges (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .ev (ev)
    );

    adc_seq_count #(.W(CNT_W), .LIMIT(FRAME_LEN)) u_fall_cnt (
        .clk (clk), .rst (rst), .clr (ev.cs_fall), .inc (ev.clk_fall), .cnt (fall_cnt)
    );

    adc_seq_count #(.W(CNT_W), .LIMIT(FRAME_LEN)) u_rise_cnt (
        .clk (clk), .rst (rst), .clr (ev.cs_fall), .inc (ev.clk_rise), .cnt (rise_cnt)
    );

    adc_seq_mode #(.RESET_SHUTDOWN(RESET_SHUTDOWN)) u_mode (
        .clk (clk), .rst (rst), .ev (ev), .fall_cnt (fall_cnt),
        .mode (mode), .invalid (invalid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sdata_oe <= 1'b0;
            hold     <= 1'b0;
            word_q   <= '0;
        end else if (ev.cs_fall) begin
            sdata_oe <= 1'b1;
            hold     <= 1'b1;
            word_q   <= core_data;
        end else if (ev.cs_rise) begin
            sdata_oe <= 1'b0;
            hold     <= 1'b0;
        end else begin
            if (ev.clk_fall && fall_cnt == LAST_FALL) sdata_oe <= 1'b0;
            if (ev.clk_rise && rise_cnt == LAST_HOLD) hold     <= 1'b0;
        end
    end

    assign sdata = sdata_oe & frame_bit(fall_cnt, word_q);
    assign pmode = mode;

    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        ev.cs_fall |=> (sdata_oe && hold));
    a_r6_abort: assert property (@(posedge clk) disable iff (rst)
        ev.cs_rise |=> (!sdata_oe && !hold));
    a_r5_window: assert property (@(posedge clk) disable iff (rst)
        sdata_oe |-> fall_cnt != FRAME_C);
    a_r4_track: assert property (@(posedge clk) disable iff (rst)
        rise_cnt >= HOLD_C |-> !hold);
    a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
        !sdata_oe |-> !sdata);

endmodule

// File: tb/sim_adc_serial_seq.sv
module sim_adc_serial_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic [9:0] core_data = '0;

    logic       sdata0, oe0, hold0, inv0;
    logic [1:0] mode0;
    logic       sdata1, oe1, hold1, inv1;
    logic [1:0] mode1;

    int checks = 0;
    int errors = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adc_serial_seq #(.RESET_SHUTDOWN(1'b0)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .core_data(core_data),
        .sdata(sdata0), .sdata_oe(oe0), .hold(hold0), .pmode(mode0), .invalid(inv0)
    );

    adc_serial_seq #(.RESET_SHUTDOWN(1'b1)) u1 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .core_data(core_data),
        .sdata(sdata1), .sdata_oe(oe1), .hold(hold1), .pmode(mode1), .invalid(inv1)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model for u0 (reset mode normal)
    int m_csq, m_sclkq, m_falls, m_rises, m_oe, m_hold, m_mode, m_need, m_inv;
    logic [9:0] m_word;

    always @(posedge clk) begin
        bit cf, cr, inf, sf, sr;
        if (rst) begin
            m_csq = 1; m_sclkq = 0; m_falls = 0; m_rises = 0; m_oe = 0;
            m_hold = 0; m_mode = 0; m_need = 1; m_inv = 0; m_word = '0;
        end else begin
            cf  = (m_csq == 1) && !cs_n;
            cr  = (m_csq == 0) && cs_n;
            inf = (m_csq == 0) && !cs_n;
            sf  = (m_sclkq == 1) && !sclk;
            sr  = (m_sclkq == 0) && sclk;
            if (cf) begin
                m_falls = 0; m_rises = 0; m_oe = 1; m_hold = 1; m_word = core_data;
                m_inv = m_need; m_need = 0;
                if (m_mode == 1) m_mode = 2;
            end else if (cr) begin
                m_oe = 0; m_hold = 0;
                if ((m_mode == 2 && m_falls < 10) ||
                    (m_mode == 0 && m_falls >= 2 && m_falls < 10)) begin
                    m_mode = 1; m_need = 1;
                end
            end else if (inf) begin
                if (sf && m_falls < 16) begin
                    m_falls++;
                    if (m_falls == 16) m_oe = 0;
                    if (m_falls == 10 && m_mode == 2) m_mode = 0;
                end
                if (sr && m_rises < 16) begin
                    m_rises++;
                    if (m_rises == 13) m_hold = 0;
                end
            end
            m_csq   = cs_n ? 1 : 0;
            m_sclkq = sclk ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        int eb;
        if (armed && !rst) begin
            eb = (m_oe == 1 && m_falls >= 4 && m_falls <= 13) ? int'(m_word[13 - m_falls]) : 0;
            chk("R3 model sdata", int'(sdata0), eb);
            chk("R5 model sdata_oe", int'(oe0), m_oe);
            chk("R4 model hold", int'(hold0), m_hold);
            chk("R8 model pmode", int'(mode0), m_mode);
            chk("R11 model invalid", int'(inv0), m_inv);
        end
    end

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            sclk = 1'b1; @(negedge clk); @(negedge clk);
            sclk = 1'b0; @(negedge clk); @(negedge clk);
        end
    endtask

    task automatic run_frame(input logic [9:0] d, input int n, output logic [15:0] cap);
        core_data = d; cs_n = 1'b0;
        @(negedge clk);
        chk("R2 oe at frame start", int'(oe0), 1);
        chk("R2 hold at frame start", int'(hold0), 1);
        @(negedge clk);
        core_data = ~d;
        cap = '0;
        cap[15] = sdata0;
        for (int k = 1; k <= n; k++) begin
            sclk = 1'b1; @(negedge clk); @(negedge clk);
            if (k == 12) chk("R4 hold before 13th rise", int'(hold0), 1);
            if (k == 13) chk("R4 track at 13th rise", int'(hold0), 0);
            sclk = 1'b0; @(negedge clk); @(negedge clk);
            if (k <= 15) cap[15 - k] = sdata0;
            if (k >= 16) begin
                chk("R5 oe off from 16th fall", int'(oe0), 0);
                chk("R5 sdata quiet after 16th fall", int'(sdata0), 0);
            end
        end
        cs_n = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] cap;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        armed = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", int'(oe0), 0);
        chk("R1 hold", int'(hold0), 0);
        chk("R1 sdata", int'(sdata0), 0);
        chk("R1 invalid", int'(inv0), 0);
        chk("R1 mode normal reset", int'(mode0), 0);
        chk("R1 mode shutdown reset", int'(mode1), 1);

        // First frame after reset: full word plus extra clocks
        run_frame(10'h2B5, 18, cap);
        chk("R3 word order", int'(cap), int'({4'b0000, 10'h2B5, 2'b00}));
        chk("R11 first frame after reset", int'(inv0), 1);
        chk("R9 full frame keeps normal", int'(mode0), 0);
        chk("R10 shutdown reset wakes", int'(mode1), 0);
        chk("R11 dummy after shutdown reset", int'(inv1), 1);

        run_frame(10'h1C3, 16, cap);
        chk("R3 second word", int'(cap), int'({4'b0000, 10'h1C3, 2'b00}));
        chk("R11 later frame valid", int'(inv0), 0);

        run_frame(10'h3FF, 1, cap);
        chk("R7 early rise keeps normal", int'(mode0), 0);

        run_frame(10'h155, 12, cap);
        chk("R9 late rise keeps normal", int'(mode0), 0);
        chk("R6 oe off after rise", int'(oe0), 0);
        chk("R6 hold off after rise", int'(hold0), 0);

        // R12: clocks outside a frame
        pulses(5);
        chk("R12 oe stays off", int'(oe0), 0);
        chk("R12 mode unchanged", int'(mode0), 0);
        run_frame(10'h001, 16, cap);
        chk("R12 next frame counts from zero", int'(cap), int'({4'b0000, 10'h001, 2'b00}));

        run_frame(10'h0AA, 5, cap);
        chk("R8 mid rise enters shutdown", int'(mode0), 1);

        // From shutdown: aborted power-up
        core_data = 10'h123; cs_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10 powering up", int'(mode0), 2);
        chk("R11 wake frame dummy", int'(inv0), 1);
        pulses(6);
        cs_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 early rise back to shutdown", int'(mode0), 1);

        run_frame(10'h2F0, 16, cap);
        chk("R10 full frame wakes", int'(mode0), 0);
        chk("R11 dummy after shutdown", int'(inv0), 1);
        chk("R3 word after wake", int'(cap), int'({4'b0000, 10'h2F0, 2'b00}));

        run_frame(10'h30F, 16, cap);
        chk("R11 valid after wake", int'(inv0), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule